// File: doc/BRIEF.md
# Dual-Register Dither Noise Source

This block makes a one-bit pseudo-noise dither value for an in-phase path and for a quadrature path. A mixer stage downstream adds these bits to its samples. The noise comes from two free-running linear feedback shift registers of different lengths: a 23-bit register with period 2^23-1 and a 15-bit register with period 2^15-1. The block XORs their output bits, so the combined stream repeats far less often than either register alone.

Each register has its own enable, and either one or both can be switched off. A register that is switched off keeps its contents and adds nothing to the XOR. When the offset control is set, the in-phase bit also takes bit 10 of the long register into its XOR, which decorrelates the I stream from the Q stream. When the offset control is clear, both paths get the same bit. A synchronous reset loads all ones into both registers, so neither register can ever reach the all-zero state, in which it would stick.

Top module: `pnDither`

## Requirements
- R1: A cycle with `rst` high loads all ones into both registers at the clock edge. Right after reset, with both enables set and offset clear, `qPn` and `iPn` are 0.
- R2: The long register is 23 bits wide, with bits numbered 0 to 22. On each clock edge where `longEn` is high and `rst` is low, it shifts one place toward its MSB, and bit 0 takes bit 22 XOR bit 17 (polynomial x^23+x^18+1). Its output bit is bit 22.
- R3: The short register is 15 bits wide, with bits numbered 0 to 14. On each clock edge where `shortEn` is high and `rst` is low, it shifts toward its MSB, and bit 0 takes bit 14 XOR bit 13 (polynomial x^15+x^14+1). Its output bit is bit 14, and that output repeats every 32767 steps.
- R4: `qPn` is the XOR of the output bits of the enabled registers. A register whose enable is low contributes 0, so with both enables low `qPn` is 0.
- R5: A register whose enable is low keeps its state unchanged. When the enable is set again, the sequence resumes from the held state.
- R6: When `offsetEn` is high, `iPn` equals `qPn` XOR bit 10 of the long register. This holds whether or not `longEn` is set.
- R7: When `offsetEn` is low, `iPn` equals `qPn`.
- R8: Neither register is ever all zeros after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads all ones into both registers |
| longEn | input | 1 | Step and mix enable for the 2^23-1 register |
| shortEn | input | 1 | Step and mix enable for the 2^15-1 register |
| offsetEn | input | 1 | XORs long-register bit 10 into the I output |
| iPn | output | 1 | In-phase dither bit |
| qPn | output | 1 | Quadrature dither bit |

## Verification
Two things can land in the same cycle: a register stepping, and its contribution to the output being gated off or its offset tap being XORed into the I path. The bench provokes this by changing the enables and the offset control between edges while both registers are running. It then compares both output bits every cycle against a bench model built from the polynomials in R2 and R3. Holding is judged by re-enabling a register after a pause and checking that the model, which was held over the same cycles, still matches. The short register's period is measured from the output alone, by finding where the run of fifteen ones comes back.

// File: rtl/pnDitherPkg.sv
package pnDitherPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic seed;       // load all-ones seed
    logic stepLong;   // advance long register
    logic stepShort;  // advance short register
    logic mixLong;    // long output contributes to XOR
    logic mixShort;   // short output contributes to XOR
    logic offsetOn;   // decorrelate I path
  } pnStrobeT;
endpackage

// File: rtl/pnLfsr.sv
module pnLfsr #(
  parameter int LEN = 15,
  parameter int TAP = 14
) (
  input  logic           clk,
  input  logic           seed,
  input  logic           step,
  output logic [LEN-1:0] state,
  output logic           msb
);
  localparam int TOP = LEN - 1;
  localparam int TIDX = TAP - 1;

  always_ff @(posedge clk) begin
    if (seed)
      state <= '1;
    else if (step)
      state <= {state[TOP-1:0], state[TOP] ^ state[TIDX]};
  end

  assign msb = state[TOP];

  AST_SEED_ONES: assert property (@(posedge clk) seed |=> (state == '1)); // R1
  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (seed) state != '0); // R8
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (seed)
    !step |=> $stable(state)); // R5
  AST_FEEDBACK_BIT: assert property (@(posedge clk) disable iff (seed)
    step |=> (state[0] == $past(state[TOP] ^ state[TIDX])) && (state[TOP:1] == $past(state[TOP-1:0]))); // R2, R3
endmodule

// File: rtl/pnCtrl.sv
module pnCtrl
  import pnDitherPkg::*;
(
  input  logic     rst,
  input  logic     longEn,
  input  logic     shortEn,
  input  logic     offsetEn,
  output pnStrobeT strb
);
  always_comb begin
    strb.seed      = rst;
    strb.stepLong  = longEn & ~rst;
    strb.stepShort = shortEn & ~rst;
    strb.mixLong   = longEn;
    strb.mixShort  = shortEn;
    strb.offsetOn  = offsetEn;
  end
endmodule

// File: rtl/pnDatapath.sv
module pnDatapath
  import pnDitherPkg::*;
#(
  parameter int LONG_LEN   = 23,
  parameter int LONG_TAP   = 18,
  parameter int SHORT_LEN  = 15,
  parameter int SHORT_TAP  = 14,
  parameter int OFFSET_BIT = 10
) (
  input  logic     clk,
  input  pnStrobeT strb,
  output logic     iPn,
  output logic     qPn
);
  logic [LONG_LEN-1:0]  longState;
  logic [SHORT_LEN-1:0] shortState;
  logic longBit, shortBit, mixed, offsetBit;

  pnLfsr #(.LEN(LONG_LEN), .TAP(LONG_TAP)) i_longReg (
    .clk(clk), .seed(strb.seed), .step(strb.stepLong),
    .state(longState), .msb(longBit));

  pnLfsr #(.LEN(SHORT_LEN), .TAP(SHORT_TAP)) i_shortReg (
    .clk(clk), .seed(strb.seed), .step(strb.stepShort),
    .state(shortState), .msb(shortBit));

  always_comb begin
    mixed     = (longBit & strb.mixLong) ^ (shortBit & strb.mixShort);
    offsetBit = longState[OFFSET_BIT] & strb.offsetOn;
    qPn       = mixed;
    iPn       = mixed ^ offsetBit;
  end

  AST_SAME_WITHOUT_OFFSET: assert property (@(posedge clk) disable iff (strb.seed)
    !strb.offsetOn |-> (iPn == qPn)); // R7
  AST_OFFSET_TAP: assert property (@(posedge clk) disable iff (strb.seed)
    strb.offsetOn |-> ((iPn ^ qPn) == longState[OFFSET_BIT])); // R6
  AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (strb.seed)
    (!strb.mixLong && !strb.mixShort) |-> !qPn); // R4
  AST_SHORT_ONLY: assert property (@(posedge clk) disable iff (strb.seed)
    (!strb.mixLong && strb.mixShort) |-> (qPn == shortState[SHORT_LEN-1])); // R4
endmodule

// File: rtl/pnDither.sv
module pnDither
  import pnDitherPkg::*;
#(
  parameter int LONG_LEN   = 23,
  parameter int LONG_TAP   = 18,
  parameter int SHORT_LEN  = 15,
  parameter int SHORT_TAP  = 14,
  parameter int OFFSET_BIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic longEn,
  input  logic shortEn,
  input  logic offsetEn,
  output logic iPn,
  output logic qPn
);
  pnStrobeT strb;

  pnCtrl i_ctrl (
    .rst(rst), .longEn(longEn), .shortEn(shortEn),
    .offsetEn(offsetEn), .strb(strb));

  pnDatapath #(
    .LONG_LEN(LONG_LEN), .LONG_TAP(LONG_TAP),
    .SHORT_LEN(SHORT_LEN), .SHORT_TAP(SHORT_TAP),
    .OFFSET_BIT(OFFSET_BIT)
  ) i_dp (
    .clk(clk), .strb(strb), .iPn(iPn), .qPn(qPn));
endmodule

// File: tb/test_pnDither.sv
module test_pnDither;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic longEn = 1'b1, shortEn = 1'b1, offsetEn = 1'b0;
  logic iPn, qPn;
  int testsRun = 0, testsFailed = 0;
  logic [22:0] mLong;
  logic [14:0] mShort;

  always #2 clk = ~clk;

  pnDither i_pnDither (
    .clk(clk), .rst(rst), .longEn(longEn), .shortEn(shortEn),
    .offsetEn(offsetEn), .iPn(iPn), .qPn(qPn));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock; model follows R1..R3
  task automatic tick();
    @(posedge clk);
    #1;
    if (rst) begin
      mLong = '1; mShort = '1;
    end else begin
      if (longEn)  mLong  = {mLong[21:0], mLong[22] ^ mLong[17]};
      if (shortEn) mShort = {mShort[13:0], mShort[14] ^ mShort[13]};
    end
  endtask

  function automatic logic expQ();
    return (longEn & mLong[22]) ^ (shortEn & mShort[14]);
  endfunction

  function automatic logic expI();
    return expQ() ^ (offsetEn & mLong[10]);
  endfunction

  task automatic doReset();
    rst = 1'b1;
    tick();
    rst = 1'b0;
  endtask

  // Run n cycles comparing against model; one check per window
  task automatic runCompare(input int n, input string req);
    bit bad = 0;
    int aq = 0, eq = 0, ai = 0, ei = 0;
    for (int k = 0; k < n; k++) begin
      tick();
      if (!bad && (qPn !== expQ() || iPn !== expI())) begin
        bad = 1; aq = qPn; eq = expQ(); ai = iPn; ei = expI();
      end
    end
    check(!bad, req, aq * 2 + ai, eq * 2 + ei);
  endtask

  task automatic tReset();
    longEn = 1; shortEn = 1; offsetEn = 0;
    doReset();
    check(qPn === 1'b0, "R1 q after reset", qPn, 0);
    check(iPn === 1'b0, "R1 i after reset", iPn, 0);
    offsetEn = 1; #1;
    check(iPn === 1'b1, "R6 i offset at seed", iPn, 1);
    offsetEn = 0;
  endtask

  // Period of short register from the output alone
  task automatic tShortPeriod();
    int run = 0, found = -1;
    bit bad = 0;
    longEn = 0; shortEn = 1; offsetEn = 0;
    doReset();
    for (int t = 0; t < 32800; t++) begin
      if (t > 0) tick();
      if (qPn !== expQ()) bad = 1;
      run = (qPn === 1'b1) ? run + 1 : 0;
      if (t > 14 && run >= 15 && found < 0) found = t;
    end
    check(found == 32781, "R3 short period", found, 32781);
    check(!bad, "R3 short sequence", bad, 0);
  endtask

  task automatic tLongAlone();
    longEn = 1; shortEn = 0; offsetEn = 0;
    doReset();
    runCompare(20000, "R2 long sequence");
  endtask

  task automatic tCombined();
    longEn = 1; shortEn = 1; offsetEn = 0;
    doReset();
    runCompare(15000, "R4 combined XOR");
    runCompare(3000, "R7 i equals q");
  endtask

  task automatic tHold();
    longEn = 1; shortEn = 1; offsetEn = 0;
    doReset();
    runCompare(500, "R4 before hold");
    longEn = 0;
    runCompare(777, "R5 long held, contributes 0");
    longEn = 1;
    runCompare(2000, "R5 long resumes");
    shortEn = 0;
    runCompare(333, "R5 short held, contributes 0");
    shortEn = 1;
    runCompare(2000, "R5 short resumes");
  endtask

  task automatic tBothOff();
    bit bad = 0;
    longEn = 1; shortEn = 1; offsetEn = 0;
    doReset();
    runCompare(100, "R4 warmup");
    longEn = 0; shortEn = 0;
    for (int k = 0; k < 200; k++) begin
      tick();
      if (qPn !== 1'b0) bad = 1;
    end
    check(!bad, "R4 both off q is 0", bad, 0);
    offsetEn = 1;
    runCompare(50, "R6 offset with long off");
    offsetEn = 0;
  endtask

  task automatic tOffset();
    longEn = 1; shortEn = 1; offsetEn = 1;
    doReset();
    runCompare(10000, "R6 offset tap");
    offsetEn = 0;
    runCompare(500, "R7 offset cleared");
    offsetEn = 1; shortEn = 0;
    runCompare(1000, "R6 offset long only");
    offsetEn = 0; shortEn = 1;
  endtask

  initial begin
    mLong = '1; mShort = '1;
    tReset();
    tShortPeriod();
    tLongAlone();
    tCombined();
    tHold();
    tBothOff();
    tOffset();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(4 * 150000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule